// File: doc/BRIEF.md
# Complementary PWM Generator with Bus-Written Settings

This block drives a pair of complementary switching outputs for a power stage. A host processor programs it through a simple 8-bit write-only parallel bus. One register holds the pulse-width number (0 to 255), which sets the on-share of the primary output. A second register holds the clock prescale, the dead-time, the output enable, run/stop, and a sticky protection lock. Both outputs are computed from a free-running 8-bit cycle counter that advances once per prescaled tick.

A dead gap is inserted once per PWM cycle, at the start of the cycle. The primary output is held off for the programmed number of counter steps after the counter wraps. If the requested on-time does not exceed that gap, the primary output stays off for the whole cycle. A pulse-width value written while the generator runs waits in a holding latch and takes over at the next wrap. A pulse is therefore never cut short or doubled.

The bus carries no back-pressure. Every write strobed with the select is accepted in the clock cycle it is sampled, so no valid/ready pair is needed. Control changes act on the outputs right after the clock edge that captures them.

Top module: `cpwm_gen`

## Requirements
- R1: A synchronous active-low reset clears the pulse-width latch, the control latch and the lock. After the reset edge, both outputs are low and the generator is stopped.
- R2: A write happens on a rising clock edge where hb_sel and hb_wr are both high. With hb_addr = 0, hb_data goes to the pulse-width latch. With hb_addr = 1, it goes to the control latch. Writes without both strobes change nothing, and control writes act on the outputs right after their capturing edge.
- R3: Control bits [1:0] set the prescale (codes 0..3 divide by 1, 2, 4, 8). While running, the 8-bit counter advances by one every prescaled tick and wraps 255 to 0, so one PWM cycle lasts 256 times the divisor in clocks.
- R4: With zero dead-time, pwm_p is high while count < pulse width and pwm_n is high while count >= pulse width. Pulse width 0 keeps pwm_p low for the whole cycle.
- R5: Control bits [3:2] set the dead-time (codes 0..3 give 0, 2, 4, 8 counter steps). pwm_p stays low for that many steps after each counter wrap, and this is the only gap in the cycle.
- R6: When the pulse width is not larger than the dead-time, pwm_p stays low for the entire cycle.
- R7: pwm_p and pwm_n are never high in the same clock cycle.
- R8: A pulse width written while running takes effect when the counter next wraps to 0. While stopped, the latch value is used directly.
- R9: Control bit 5 = 0 (stop) forces both outputs low and holds the counter and prescaler at zero. Setting it again starts a cycle at count 0.
- R10: Control bit 4 = 0 forces both outputs low while the counter keeps running.
- R11: Writing control bit 6 = 1 sets a lock that forces both outputs low. Later control writes with bit 6 = 0 do not clear it; only reset does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hb_sel | input | 1 | Host bus select, active high |
| hb_wr | input | 1 | Host bus write strobe, active high |
| hb_addr | input | 1 | Register select: 0 pulse width, 1 control |
| hb_data | input | 8 | Write data |
| pwm_p | output | 1 | Primary PWM output |
| pwm_n | output | 1 | Complementary PWM output |

## Verification
On every cycle, the checker confirms several invariants. The two outputs never overlap. The lock never clears outside reset and keeps both outputs quiet. A stopped generator parks its counter at zero. The counter only steps by one or returns to zero. The primary output never appears inside the dead gap. Other behaviour can only be shown by the bench's scenarios, which compare every cycle against an independent model and measure on-time over whole periods. These scenarios cover the exact duty share for each prescale and dead-time code, the suppression of short pulses, and the deferral of a mid-cycle pulse-width write to the next wrap. They also cover the restart of a stopped cycle at count 0, and the phase that continues under a disabled output.

// File: rtl/cpwm_pkg.sv
`timescale 1ns/1ps
package cpwm_pkg;
  // control latch fields; member order fixes bit positions 5..0
  typedef struct packed {
    logic       run;
    logic       out_en;
    logic [1:0] dt_code;
    logic [1:0] div_code;
  } ctrl_t;

  localparam int CTRL_BITS = $bits(ctrl_t);
  localparam int LOCK_BIT  = 6;

  // dead-time steps per code: 0, 2, 4, 8
  function automatic int unsigned dead_steps(input logic [1:0] code);
    return (code == 2'd0) ? 0 : (32'd1 << code);
  endfunction
endpackage

// File: rtl/cpwm_bus_regs.sv
`timescale 1ns/1ps
module cpwm_bus_regs
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hb_sel,
  input  logic             hb_wr,
  input  logic             hb_addr,
  input  logic [CNT_W-1:0] hb_data,
  output logic [CNT_W-1:0] pw_hold,
  output ctrl_t            ctrl,
  output logic             locked
);
  logic wr_hit;
  assign wr_hit = hb_sel & hb_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pw_hold <= '0;
      ctrl    <= '0;
      locked  <= 1'b0;
    end else if (wr_hit) begin
      if (!hb_addr) begin
        pw_hold <= hb_data;
      end else begin
        ctrl <= ctrl_t'(hb_data[CTRL_BITS-1:0]);
        if (hb_data[LOCK_BIT]) locked <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cpwm_timebase.sv
`timescale 1ns/1ps
module cpwm_timebase #(
  parameter int CNT_W = 8,
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_code,
  input  logic [CNT_W-1:0] pw_hold,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] pw_live
);
  localparam int PSC_W = (1 << DIV_W) - 1;

  logic [PSC_W-1:0] psc;
  logic [PSC_W-1:0] psc_lim;
  logic             tick;
  logic             wrap;

  assign psc_lim = PSC_W'((32'd1 << div_code) - 32'd1);
  assign tick    = (psc == psc_lim);
  assign wrap    = (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      psc     <= '0;
      cnt     <= '0;
      pw_live <= '0;
    end else if (!run) begin
      psc     <= '0;
      cnt     <= '0;
      pw_live <= pw_hold;
    end else begin
      psc <= tick ? '0 : psc + 1'b1;
      if (tick) begin
        cnt <= cnt + 1'b1;
        if (wrap) pw_live <= pw_hold;
      end
    end
  end
endmodule

// File: rtl/cpwm_outstage.sv
`timescale 1ns/1ps
module cpwm_outstage
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] pw_live,
  input  logic [1:0]       dt_code,
  input  logic             run,
  input  logic             out_en,
  input  logic             locked,
  output logic             pwm_p,
  output logic             pwm_n
);
  logic [CNT_W-1:0] dt_lim;
  logic             live;
  logic             below_pw;
  logic             past_gap;

  assign dt_lim   = CNT_W'(dead_steps(dt_code));
  assign live     = run & out_en & ~locked;
  assign below_pw = (cnt < pw_live);
  assign past_gap = (cnt >= dt_lim);
  assign pwm_p    = live & below_pw & past_gap;
  assign pwm_n    = live & ~below_pw;
endmodule

// File: rtl/cpwm_gen.sv
`timescale 1ns/1ps
module cpwm_gen
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hb_sel,
  input  logic             hb_wr,
  input  logic             hb_addr,
  input  logic [CNT_W-1:0] hb_data,
  output logic             pwm_p,
  output logic             pwm_n
);
  ctrl_t            ctrl;
  logic             locked;
  logic [CNT_W-1:0] pw_hold;
  logic [CNT_W-1:0] pw_live;
  logic [CNT_W-1:0] cnt;

  cpwm_bus_regs #(.CNT_W(CNT_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .hb_sel  (hb_sel),
    .hb_wr   (hb_wr),
    .hb_addr (hb_addr),
    .hb_data (hb_data),
    .pw_hold (pw_hold),
    .ctrl    (ctrl),
    .locked  (locked)
  );

  cpwm_timebase #(.CNT_W(CNT_W), .DIV_W(2)) u_tb (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (ctrl.run),
    .div_code (ctrl.div_code),
    .pw_hold  (pw_hold),
    .cnt      (cnt),
    .pw_live  (pw_live)
  );

  cpwm_outstage #(.CNT_W(CNT_W)) u_out (
    .cnt     (cnt),
    .pw_live (pw_live),
    .dt_code (ctrl.dt_code),
    .run     (ctrl.run),
    .out_en  (ctrl.out_en),
    .locked  (locked),
    .pwm_p   (pwm_p),
    .pwm_n   (pwm_n)
  );
endmodule

// File: rtl/cpwm_gen_chk.sv
`timescale 1ns/1ps
module cpwm_gen_chk
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwm_p,
  input logic             pwm_n,
  input logic             run,
  input logic             locked,
  input logic [1:0]       dt_code,
  input logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] gap;
  assign gap = CNT_W'(dead_steps(dt_code));

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!pwm_p && !pwm_n));

  // R7
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwm_p && pwm_n));

  // R11
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  // R11
  lock_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (!pwm_p && !pwm_n));

  // R9
  stop_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt) |-> ((cnt == CNT_W'($past(cnt) + 1'b1)) || (cnt == '0)));

  // R5
  gap_respect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_p |-> (cnt >= gap));
endmodule

bind cpwm_gen cpwm_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pwm_p   (pwm_p),
  .pwm_n   (pwm_n),
  .run     (ctrl.run),
  .locked  (locked),
  .dt_code (ctrl.dt_code),
  .cnt     (cnt)
);

// File: tb/cpwm_gen_test.sv
`timescale 1ns/1ps
module cpwm_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hb_sel = 1'b0;
  logic       hb_wr = 1'b0;
  logic       hb_addr = 1'b0;
  logic [7:0] hb_data = 8'h00;
  logic       pwm_p;
  logic       pwm_n;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  cpwm_gen uut (
    .clk(clk), .rst_n(rst_n), .hb_sel(hb_sel), .hb_wr(hb_wr),
    .hb_addr(hb_addr), .hb_data(hb_data), .pwm_p(pwm_p), .pwm_n(pwm_n)
  );

  // reference model state, built from the requirements
  logic [7:0] m_pwh = 8'h00, m_pwl = 8'h00, m_ctl = 8'h00, m_cnt = 8'h00;
  logic [2:0] m_psc = 3'd0;
  logic       m_lock = 1'b0;
  logic [1:0] exp_q[$];

  always @(posedge clk) begin
    logic [2:0] lim;
    logic [7:0] gap;
    logic       on, e1, e2;
    if (!rst_n) begin
      m_pwh = 0; m_pwl = 0; m_ctl = 0; m_cnt = 0; m_psc = 0; m_lock = 0;
    end else begin
      if (!m_ctl[5]) begin
        m_psc = 0; m_cnt = 0; m_pwl = m_pwh;
      end else begin
        lim = 3'((1 << m_ctl[1:0]) - 1);
        if (m_psc == lim) begin
          m_psc = 0;
          if (m_cnt == 8'hFF) m_pwl = m_pwh;
          m_cnt = m_cnt + 8'd1;
        end else begin
          m_psc = m_psc + 3'd1;
        end
      end
      if (hb_sel && hb_wr) begin
        if (!hb_addr) m_pwh = hb_data;
        else begin
          m_ctl = hb_data;
          if (hb_data[6]) m_lock = 1'b1;
        end
      end
    end
    case (m_ctl[3:2])
      2'd0: gap = 8'd0;
      2'd1: gap = 8'd2;
      2'd2: gap = 8'd4;
      default: gap = 8'd8;
    endcase
    on = m_ctl[5] && m_ctl[4] && !m_lock;
    e1 = on && (m_cnt >= gap) && (m_cnt < m_pwl);
    e2 = on && (m_cnt >= m_pwl);
    exp_q.push_back({e1, e2});
  end

  // monitor: compare every cycle with the scoreboard entry
  always @(negedge clk) begin
    logic [1:0] e;
    if (!done && exp_q.size() > 0) begin
      e = exp_q.pop_front();
      n_chk++;
      if ({pwm_p, pwm_n} !== e) begin
        n_fail++;
        $display("FAIL %s: {pwm_p,pwm_n} got %b expected %b at %0t",
                 cur_req, {pwm_p, pwm_n}, e, $time);
      end
      n_chk++;
      if (pwm_p && pwm_n) begin
        n_fail++;
        $display("FAIL R7: both outputs high got 11 expected not 11 at %0t", $time);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    hb_sel = 1'b1; hb_wr = 1'b1; hb_addr = a; hb_data = d;
    @(negedge clk);
    hb_sel = 1'b0; hb_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // samples at the current negedge first, then n-1 further ones
  task automatic measure(input int n, output int h1, output int h2, output int hb);
    h1 = 0; h2 = 0; hb = 0;
    for (int i = 0; i < n; i++) begin
      h1 += int'(pwm_p);
      h2 += int'(pwm_n);
      hb += int'(pwm_p && pwm_n);
      @(negedge clk);
    end
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    int h1, h2, hb;
    cur_req = "R1";
    idle(4);
    chk("R1", int'(pwm_p), 0);
    chk("R1", int'(pwm_n), 0);
    rst_n = 1'b1;
    idle(3);
    chk("R1", int'(pwm_p) + int'(pwm_n), 0);

    // R4: basic duty, no dead-time, divide by 1
    cur_req = "R4";
    wr(1'b0, 8'd64);
    wr(1'b1, 8'h30);
    measure(256, h1, h2, hb);
    chk("R4", h1, 64);
    chk("R4", h2, 192);
    chk("R7", hb, 0);

    // R2: strobes not both high are ignored
    cur_req = "R2";
    @(negedge clk);
    hb_sel = 1'b0; hb_wr = 1'b1; hb_addr = 1'b1; hb_data = 8'h00;
    @(negedge clk);
    hb_sel = 1'b1; hb_wr = 1'b0;
    @(negedge clk);
    hb_sel = 1'b0;
    measure(256, h1, h2, hb);
    chk("R2", h1, 64);
    chk("R2", h2, 192);

    // R5: dead-time code 1 -> 2 steps
    cur_req = "R5";
    wr(1'b1, 8'h34);
    measure(256, h1, h2, hb);
    chk("R5", h1, 62);
    chk("R5", h2, 192);
    wr(1'b1, 8'h38);
    measure(256, h1, h2, hb);
    chk("R5", h1, 60);

    // R6: short pulse suppressed under 8-step dead-time
    cur_req = "R6";
    wr(1'b0, 8'd5);
    wr(1'b1, 8'h3C);
    idle(256);
    measure(256, h1, h2, hb);
    chk("R6", h1, 0);
    chk("R6", h2, 251);
    wr(1'b0, 8'd8);
    idle(256);
    measure(256, h1, h2, hb);
    chk("R6", h1, 0);
    wr(1'b0, 8'd9);
    idle(256);
    measure(256, h1, h2, hb);
    chk("R6", h1, 1);

    // R4: extremes
    cur_req = "R4";
    wr(1'b1, 8'h30);
    wr(1'b0, 8'd0);
    idle(256);
    measure(256, h1, h2, hb);
    chk("R4", h1, 0);
    chk("R4", h2, 256);
    wr(1'b0, 8'd255);
    idle(256);
    measure(256, h1, h2, hb);
    chk("R4", h1, 255);
    chk("R4", h2, 1);

    // R9: stop, then restart at count 0
    cur_req = "R9";
    wr(1'b0, 8'd64);
    wr(1'b1, 8'h10);
    chk("R2", int'(pwm_p) + int'(pwm_n), 0);
    measure(300, h1, h2, hb);
    chk("R9", h1 + h2, 0);
    wr(1'b1, 8'h30);
    measure(64, h1, h2, hb);
    chk("R9", h1, 64);
    chk("R9", h2, 0);

    // R8: mid-cycle pulse-width write waits for wrap
    cur_req = "R8";
    wr(1'b1, 8'h10);
    wr(1'b1, 8'h30);
    idle(100);
    wr(1'b0, 8'd200);
    measure(100, h1, h2, hb);
    chk("R8", h1, 0);
    chk("R8", h2, 100);
    idle(60);
    measure(256, h1, h2, hb);
    chk("R8", h1, 200);

    // R3: prescale divide by 4 (restart from stop)
    cur_req = "R3";
    wr(1'b0, 8'd64);
    wr(1'b1, 8'h00);
    wr(1'b1, 8'h32);
    measure(1024, h1, h2, hb);
    chk("R3", h1, 256);
    chk("R3", h2, 768);
    wr(1'b1, 8'h00);
    wr(1'b1, 8'h37);
    measure(2048, h1, h2, hb);
    chk("R3", h1, 496);
    chk("R7", hb, 0);

    // R10: output disable keeps phase running
    cur_req = "R10";
    wr(1'b1, 8'h00);
    wr(1'b1, 8'h30);
    idle(30);
    wr(1'b1, 8'h20);
    chk("R2", int'(pwm_p) + int'(pwm_n), 0);
    measure(200, h1, h2, hb);
    chk("R10", h1 + h2, 0);
    wr(1'b1, 8'h30);
    idle(500);

    // R11: lock is sticky and silences outputs
    cur_req = "R11";
    wr(1'b1, 8'h70);
    measure(256, h1, h2, hb);
    chk("R11", h1 + h2, 0);
    wr(1'b1, 8'h30);
    measure(256, h1, h2, hb);
    chk("R11", h1 + h2, 0);

    cur_req = "R1";
    @(negedge clk);
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    chk("R1", int'(pwm_p) + int'(pwm_n), 0);
    wr(1'b1, 8'h30);
    measure(256, h1, h2, hb);
    chk("R1", h1, 0);
    chk("R1", h2, 256);
    wr(1'b0, 8'd64);
    idle(256);
    measure(256, h1, h2, hb);
    chk("R11", h1, 64);

    idle(2);
    report();
  end
endmodule